// File: doc/BRIEF.md
# Dual-Bank GPIO Controller

This block is a general-purpose I/O peripheral with two independent pin banks, a core bank of ten pins and a resume bank of four pins. Both banks sit behind one byte-wide register bus. Each bank holds three registers: a per-pin enable, a per-pin direction and a per-pin level. Eight pins are packed into each register byte. Software uses the direction register to turn pins into outputs and drives them through the level register. Reading the level register returns the synchronized pad inputs.

Every pin has a tri-state pad interface made of an output value, an output enable and an input value. A pad is driven only when its pin is enabled, its direction is output, and the pin is not held back for another function. Core pin 7 is held back in this way. The level register accepts writes only on pins that are currently outputs. This means a level cannot be preset while the pin is still an input. A stored level survives a trip through input mode.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset the pad output enables and pad outputs are all 0 and read data is 0x00. The enable reads 0x7F at 0x00 and 0x00 at 0x01, and 0x07 at 0x20. The direction reads 0xFF at 0x04, 0x03 at 0x05 and 0x0F at 0x24. Level bits reset to 0.
- R2: The address decode works as follows. bus_addr[5] selects the bank (0 core, 1 resume) and bus_addr[4] must be 0. bus_addr[3:2] selects the register (0 enable, 1 direction, 2 level). bus_addr[1:0] selects the register byte.
- R3: Pin n lives in register byte n/8, bit n%8. Writing 0x03 to 0x01 enables core pins 9 and 8, and writing 0x08 to 0x20 leaves only resume pin 3 enabled. An enable write replaces the whole byte.
- R4: A direction bit of 1 means input and 0 means output. pad_oe for a pin is 1 exactly when the pin is enabled, its direction bit is 0 and it is not reserved.
- R5: A write to a level bit changes the stored level, visible on pad_out, only when that pin's direction bit is 0. Level bits of input pins are left unchanged.
- R6: A level register read returns the pad inputs after a two-flop synchronizer. A pad change made before clock edge k appears in read data captured at edge k+2 and later, and not in data captured at edge k+1.
- R7: Bits above a bank's pin count read 0. Unmapped addresses read 0x00: register code 3, bus_addr[4]=1, or a byte index beyond the bank. Writes to unmapped addresses change nothing.
- R8: Core pin 7 is reserved. Its enable bit reads 0 even after writing 1, and its pad_oe is never asserted.
- R9: A level written while a pin is an output is kept while the pin is an input. It drives pad_out again when the pin returns to output.
- R10: bus_rdata is registered. It takes the addressed byte at the clock edge where bus_rd is sampled high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| core_pad_in | input | 10 | Core bank pad inputs |
| core_pad_out | output | 10 | Core bank pad output values |
| core_pad_oe | output | 10 | Core bank pad output enables |
| rsm_pad_in | input | 4 | Resume bank pad inputs |
| rsm_pad_out | output | 4 | Resume bank pad output values |
| rsm_pad_oe | output | 4 | Resume bank pad output enables |

## Verification
The bench writes level bytes that mix input and output pins. A design that ignored the direction mask would change pad_out on input pins. It flips a whole byte to input, writes zeros, and flips it back, which catches a design that clears or overwrites the stored level while a pin is an input. It sets the reserved core pin to output with enable written 1, so a design that forgot the reservation would drive that pad. It reads the level register one and two edges after a pad change, which catches a synchronizer that is too short or too long. It also reads byte indices beyond each bank, register code 3 and the upper address half, which catches decode aliasing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BYTE_W = 8;

    // register select code taken from bus_addr[3:2]
    typedef enum logic [1:0] {
        REG_EN   = 2'd0,
        REG_DIR  = 2'd1,
        REG_LVL  = 2'd2,
        REG_NONE = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int               NPINS    = 10,
    parameter int               IDX_W    = 2,
    parameter logic [NPINS-1:0] RST_EN   = '0,
    parameter logic [NPINS-1:0] RSV_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  gpio_reg_e         reg_sel,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    localparam int NBYTES = (NPINS + BYTE_W - 1) / BYTE_W;
    localparam int PADDED = NBYTES * BYTE_W;

    logic [NPINS-1:0]  en_q;
    logic [NPINS-1:0]  dir_q;
    logic [NPINS-1:0]  lvl_q;
    logic [NPINS-1:0]  in_sync;
    logic [PADDED-1:0] en_p;
    logic [PADDED-1:0] dir_p;
    logic [PADDED-1:0] in_p;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    // register writes; level bits only move on output pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= RST_EN & ~RSV_MASK;
            dir_q <= '1;
            lvl_q <= '0;
        end else if (sel && wr) begin
            for (int n = 0; n < NPINS; n++) begin
                if (byte_idx == IDX_W'(n / BYTE_W)) begin
                    unique case (reg_sel)
                        REG_EN:  en_q[n]  <= wdata[n % BYTE_W] & ~RSV_MASK[n];
                        REG_DIR: dir_q[n] <= wdata[n % BYTE_W];
                        REG_LVL: if (!dir_q[n]) lvl_q[n] <= wdata[n % BYTE_W];
                        default: ;
                    endcase
                end
            end
        end
    end

    // read byte mux, padded bits and unmapped bytes are zero
    always_comb begin
        en_p  = '0;
        dir_p = '0;
        in_p  = '0;
        en_p[NPINS-1:0]  = en_q;
        dir_p[NPINS-1:0] = dir_q;
        in_p[NPINS-1:0]  = in_sync;
        rd_byte = '0;
        if (sel) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (byte_idx == IDX_W'(b)) begin
                    unique case (reg_sel)
                        REG_EN:  rd_byte = en_p[b*BYTE_W +: BYTE_W];
                        REG_DIR: rd_byte = dir_p[b*BYTE_W +: BYTE_W];
                        REG_LVL: rd_byte = in_p[b*BYTE_W +: BYTE_W];
                        default: rd_byte = '0;
                    endcase
                end
            end
        end
    end

    assign pad_oe  = en_q & ~dir_q & ~RSV_MASK;
    assign pad_out = lvl_q;

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
    import gpio_pkg::*;
#(
    parameter int                   CORE_PINS   = 10,
    parameter int                   RSM_PINS    = 4,
    parameter logic [CORE_PINS-1:0] CORE_RST_EN = 10'h07F,
    parameter logic [CORE_PINS-1:0] CORE_RSV    = 10'h080,
    parameter logic [RSM_PINS-1:0]  RSM_RST_EN  = 4'h7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [5:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    input  logic                 bus_rd,
    output logic [7:0]           bus_rdata,
    input  logic [CORE_PINS-1:0] core_pad_in,
    output logic [CORE_PINS-1:0] core_pad_out,
    output logic [CORE_PINS-1:0] core_pad_oe,
    input  logic [RSM_PINS-1:0]  rsm_pad_in,
    output logic [RSM_PINS-1:0]  rsm_pad_out,
    output logic [RSM_PINS-1:0]  rsm_pad_oe
);

    localparam int IDX_W = 2;

    logic        core_sel;
    logic        rsm_sel;
    gpio_reg_e   reg_sel;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]  core_rd;
    logic [7:0]  rsm_rd;

    assign core_sel = (bus_addr[5:4] == 2'b00);
    assign rsm_sel  = (bus_addr[5:4] == 2'b10);
    assign reg_sel  = gpio_reg_e'(bus_addr[3:2]);
    assign byte_idx = bus_addr[IDX_W-1:0];

    gpio_bank #(
        .NPINS    (CORE_PINS),
        .IDX_W    (IDX_W),
        .RST_EN   (CORE_RST_EN),
        .RSV_MASK (CORE_RSV)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (core_sel),
        .reg_sel  (reg_sel),
        .byte_idx (byte_idx),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .pad_in   (core_pad_in),
        .rd_byte  (core_rd),
        .pad_out  (core_pad_out),
        .pad_oe   (core_pad_oe)
    );

    gpio_bank #(
        .NPINS    (RSM_PINS),
        .IDX_W    (IDX_W),
        .RST_EN   (RSM_RST_EN),
        .RSV_MASK ('0)
    ) u_rsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (rsm_sel),
        .reg_sel  (reg_sel),
        .byte_idx (byte_idx),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .pad_in   (rsm_pad_in),
        .rd_byte  (rsm_rd),
        .pad_out  (rsm_pad_out),
        .pad_oe   (rsm_pad_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= core_rd | rsm_rd;
        end
    end

endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
    parameter int                   CORE_PINS = 10,
    parameter int                   RSM_PINS  = 4,
    parameter logic [CORE_PINS-1:0] CORE_RSV  = 10'h080
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [5:0]           bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [7:0]           bus_rdata,
    input logic [CORE_PINS-1:0] core_pad_out,
    input logic [CORE_PINS-1:0] core_pad_oe,
    input logic [RSM_PINS-1:0]  rsm_pad_out,
    input logic [RSM_PINS-1:0]  rsm_pad_oe
);

    logic unmapped;
    assign unmapped = bus_addr[4] || (bus_addr[3:2] == 2'b11);

    // R10: read data only moves on a read
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R7: unmapped reads return zero
    a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == 8'h00));

    // R7: unmapped writes leave the pads alone
    a_r7_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=> ($stable(core_pad_out) && $stable(core_pad_oe)
                                  && $stable(rsm_pad_out) && $stable(rsm_pad_oe)));

    // R8: reserved core pins are never driven
    a_r8_reserved_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (core_pad_oe & CORE_RSV) == '0);

    // R4: an output enable only rises after a register write
    a_r4_oe_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (((core_pad_oe & ~$past(core_pad_oe)) != '0)
         || ((rsm_pad_oe & ~$past(rsm_pad_oe)) != '0)) |-> $past(bus_wr));

    // R9: stored levels change only through writes
    a_r9_level_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> ($stable(core_pad_out) && $stable(rsm_pad_out)));

endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(
    .CORE_PINS (CORE_PINS),
    .RSM_PINS  (RSM_PINS),
    .CORE_RSV  (CORE_RSV)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .core_pad_out (core_pad_out),
    .core_pad_oe  (core_pad_oe),
    .rsm_pad_out  (rsm_pad_out),
    .rsm_pad_oe   (rsm_pad_oe)
);

// File: tb/tb_gpio_dual_bank.sv
module tb_gpio_dual_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [9:0] core_pad_in = '0;
    logic [9:0] core_pad_out;
    logic [9:0] core_pad_oe;
    logic [3:0] rsm_pad_in = '0;
    logic [3:0] rsm_pad_out;
    logic [3:0] rsm_pad_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpio_dual_bank dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .core_pad_in  (core_pad_in),
        .core_pad_out (core_pad_out),
        .core_pad_oe  (core_pad_oe),
        .rsm_pad_in   (rsm_pad_in),
        .rsm_pad_out  (rsm_pad_out),
        .rsm_pad_oe   (rsm_pad_oe)
    );

    // {is_read, addr, wdata, expected, requirement number}
    localparam int NV = 23;
    localparam logic [26:0] VEC [0:NV-1] = '{
        {1'b1, 6'h00, 8'h00, 8'h7F, 4'd1},   // R1 core enable byte0
        {1'b1, 6'h01, 8'h00, 8'h00, 4'd1},   // R1 core enable byte1
        {1'b1, 6'h04, 8'h00, 8'hFF, 4'd1},   // R1 core direction byte0
        {1'b1, 6'h05, 8'h00, 8'h03, 4'd7},   // R7 unused bits zero
        {1'b1, 6'h20, 8'h00, 8'h07, 4'd1},   // R1 resume enable
        {1'b1, 6'h24, 8'h00, 8'h0F, 4'd1},   // R1 resume direction
        {1'b1, 6'h08, 8'h00, 8'h00, 4'd6},   // R6 pads low
        {1'b1, 6'h02, 8'h00, 8'h00, 4'd7},   // R7 byte beyond core
        {1'b1, 6'h0C, 8'h00, 8'h00, 4'd7},   // R7 register code 3
        {1'b1, 6'h21, 8'h00, 8'h00, 4'd7},   // R7 byte beyond resume
        {1'b0, 6'h01, 8'h03, 8'h00, 4'd3},   // R3 enable pins 9,8
        {1'b1, 6'h01, 8'h00, 8'h03, 4'd3},
        {1'b0, 6'h20, 8'h08, 8'h00, 4'd3},   // R3 resume pin 3 only
        {1'b1, 6'h20, 8'h00, 8'h08, 4'd3},
        {1'b0, 6'h00, 8'hFF, 8'h00, 4'd8},   // R8 reserved enable
        {1'b1, 6'h00, 8'h00, 8'h7F, 4'd8},
        {1'b0, 6'h10, 8'hFF, 8'h00, 4'd7},   // R7 upper half write
        {1'b1, 6'h10, 8'h00, 8'h00, 4'd7},
        {1'b0, 6'h04, 8'h0F, 8'h00, 4'd2},   // R2 direction byte0
        {1'b1, 6'h04, 8'h00, 8'h0F, 4'd2},
        {1'b0, 6'h05, 8'hFE, 8'h00, 4'd2},   // R2 direction byte1
        {1'b1, 6'h05, 8'h00, 8'h02, 4'd7},
        {1'b1, 6'h3F, 8'h00, 8'h00, 4'd7}    // R7 top address
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        check("R1", "oe core at reset", 16'(core_pad_oe), 16'h000);
        check("R1", "oe resume at reset", 16'(rsm_pad_oe), 16'h0);
        check("R1", "out core at reset", 16'(core_pad_out), 16'h000);
        check("R1", "rdata at reset", 16'(bus_rdata), 16'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][26]) begin
                bus_read(VEC[i][25:20], rd);
                check($sformatf("R%0d", VEC[i][3:0]),
                      $sformatf("read addr %h", VEC[i][25:20]),
                      16'(rd), 16'(VEC[i][11:4]));
            end else begin
                bus_write(VEC[i][25:20], VEC[i][19:12]);
            end
        end

        // enable 0x37F, direction 0x20F: pins 4,5,6,8 driven; 7 reserved
        check("R4", "oe after direction set", 16'(core_pad_oe), 16'h170);
        check("R8", "reserved pin 7 undriven", 16'(core_pad_oe[7]), 16'h0);

        bus_write(6'h08, 8'hFF);
        bus_write(6'h09, 8'h03);
        check("R5", "level masked by direction", 16'(core_pad_out), 16'h1F0);

        bus_write(6'h04, 8'hFF);
        bus_write(6'h08, 8'h00);
        check("R5", "input pins ignore level write", 16'(core_pad_out), 16'h1F0);
        check("R4", "oe with byte0 inputs", 16'(core_pad_oe), 16'h100);
        bus_write(6'h04, 8'h00);
        check("R9", "level kept across input trip", 16'(core_pad_out), 16'h1F0);
        check("R8", "oe all outputs reserved off", 16'(core_pad_oe), 16'h17F);

        bus_write(6'h24, 8'h00);
        check("R4", "resume oe follows enable", 16'(rsm_pad_oe), 16'h8);
        bus_write(6'h28, 8'h0A);
        check("R5", "resume level", 16'(rsm_pad_out), 16'hA);

        // synchronizer depth
        core_pad_in = 10'h2A5;
        @(negedge clk);
        bus_read(6'h08, rd);
        check("R6", "level not visible at edge k+1", 16'(rd), 16'h00);
        bus_read(6'h08, rd);
        check("R6", "level visible at edge k+2", 16'(rd), 16'hA5);
        bus_read(6'h09, rd);
        check("R3", "pin 9 in byte1 bit1", 16'(rd), 16'h02);

        rsm_pad_in = 4'hF;
        repeat (3) @(negedge clk);
        bus_read(6'h28, rd);
        check("R6", "resume level read", 16'(rd), 16'h0F);

        bus_write(6'h28, 8'h00);
        check("R10", "rdata held without read", 16'(bus_rdata), 16'h0F);
        check("R5", "resume level cleared", 16'(rsm_pad_out), 16'h0);

        bus_write(6'h18, 8'hFF);
        bus_write(6'h2C, 8'hFF);
        check("R7", "unmapped write core out", 16'(core_pad_out), 16'h1F0);
        check("R7", "unmapped write core oe", 16'(core_pad_oe), 16'h17F);
        check("R7", "unmapped write resume out", 16'(rsm_pad_out), 16'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule